// File: doc/BRIEF.md
# Indexed Set/Clear Interrupt Controller

This block gathers level-sensitive interrupt lines from a parameterized number of sources (up to 1023) and drives one interrupt request to a single CPU. Each source has two bits of state: an enable bit and a mask bit. A source is eligible when its input is high, its enable bit is set and its mask bit is clear. The CPU request is high whenever any source is eligible.

Software never reads and rewrites these bit arrays. It changes one source at a time by writing that source's number to a dedicated register. There is one register that sets and one that clears each array. The enable registers sit in a global window, and the mask registers and the acknowledge register sit in a per-CPU window. A select input on the register bus picks the window.

The interrupt handler reads the acknowledge register over and over. Each read returns the lowest-numbered eligible source, or the code 1023 once nothing is eligible. The read has no side effects. A source stops being reported only when its line drops, or when software masks or disables it.

Top module: `irq_idx_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every mask bit is 1 and `cpu_irq` is low, whatever the source lines are. An acknowledge read returns 1023.
- R2: A write in the global window (`win_sel`=0) to offset 0x30 sets the enable bit of the source numbered `wdata[9:0]`. Data bits [31:10] are ignored.
- R3: A write in the global window to offset 0x34 clears the enable bit of source `wdata[9:0]`.
- R4: A write in the per-CPU window (`win_sel`=1) to offset 0x48 sets the mask bit of source `wdata[9:0]`, which blocks that source.
- R5: A write in the per-CPU window to offset 0x4C clears the mask bit of source `wdata[9:0]`, which lets that source through.
- R6: A read of offset 0x00 in the global window returns the number of implemented sources in bits [11:2], with all other bits 0.
- R7: A read of offset 0x44 in the per-CPU window returns, one cycle after the read strobe, the lowest-numbered eligible source in bits [9:0] with bits [31:10] zero. It returns 1023 when no source is eligible.
- R8: `cpu_irq` is high in exactly the cycles in which at least one source is eligible (line high, enabled, unmasked). It follows input and state changes with no register delay.
- R9: A set or clear write whose source number is at or above the implemented count changes no enable or mask bit.
- R10: Each offset acts only in its own window. A write to a valid offset in the wrong window, or to an unused offset, has no effect. A read of any other offset/window pair returns 0.
- R11: Reads, including acknowledge reads, change no enable or mask bit. Repeated acknowledge reads with unchanged inputs return the same number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Level interrupt lines, bit i is source i |
| win_sel | input | 1 | Register window: 0 global, 1 per-CPU |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data valid on `rdata` the next cycle |
| addr | input | ADDR_W | Byte offset within the selected window |
| wdata | input | 32 | Write data; bits [9:0] carry the source number |
| rdata | output | 32 | Read data, registered; 0 in cycles after no read |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
An enable or mask bit held in the wrong state is hidden while its source line is low. Once that line rises, the fault shows at `cpu_irq` in the same cycle and in the next acknowledge read. So the stimulus keeps many lines high and, after every change, reads the acknowledge register and compares `cpu_irq`. A wrong priority order or a lost or spurious write then shows within one read. Out-of-range numbers, wrong-window writes and ignored upper data bits are each driven against a source whose line is already high, so that any stray change of state becomes visible at once.

// File: rtl/irq_idx_ctrl.sv
module irq_idx_ctrl #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               win_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               cpu_irq
);
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = '1;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFS_ACK     = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] OFS_MSK_SET = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR = ADDR_W'(8'h4C);
  localparam logic [31:0] CTRL_WORD = {20'b0, ID_W'(NUM_SRC), 2'b00};

  logic [NUM_SRC-1:0] en, mask, elig;
  logic [ID_W-1:0]    idx, sel;
  logic               in_range, glb, pcpu;
  logic               en_set, en_clr, msk_set, msk_clr;
  logic [31:0]        rd_next;
  logic               unused_hi;

  assign idx       = wdata[ID_W-1:0];
  assign unused_hi = ^wdata[31:ID_W];
  assign in_range  = 32'(idx) < 32'(NUM_SRC);
  assign glb       = wr_en && !win_sel && in_range;
  assign pcpu      = wr_en &&  win_sel && in_range;
  assign en_set    = glb  && addr == OFS_EN_SET;
  assign en_clr    = glb  && addr == OFS_EN_CLR;
  assign msk_set   = pcpu && addr == OFS_MSK_SET;
  assign msk_clr   = pcpu && addr == OFS_MSK_CLR;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit;
    assign hit = idx == ID_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[g]   <= 1'b0;
        mask[g] <= 1'b1;
      end else begin
        if (en_set && hit)       en[g] <= 1'b1;
        else if (en_clr && hit)  en[g] <= 1'b0;
        if (msk_set && hit)      mask[g] <= 1'b1;
        else if (msk_clr && hit) mask[g] <= 1'b0;
      end
    end

    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !win_sel && addr == OFS_EN_SET && wdata[ID_W-1:0] == ID_W'(g)) |=> en[g]);
    a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && win_sel && addr == OFS_MSK_SET && wdata[ID_W-1:0] == ID_W'(g)) |=> mask[g]);
  end

  assign elig    = src_in & en & ~mask;
  assign cpu_irq = |elig;

  always_comb begin
    sel = NONE_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig[i]) sel = ID_W'(i);
  end

  always_comb begin
    rd_next = '0;
    if (win_sel && addr == OFS_ACK)   rd_next = {{(32-ID_W){1'b0}}, sel};
    if (!win_sel && addr == OFS_CTRL) rd_next = CTRL_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
    else            rdata <= '0;
  end

  a_r8_ack_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win_sel && addr == OFS_ACK) |=> ((rdata[ID_W-1:0] == NONE_ID) == !$past(cpu_irq)));
  a_r7_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win_sel && addr == OFS_ACK) |=>
      (rdata[31:ID_W] == '0 && (rdata[ID_W-1:0] == NONE_ID || 32'(rdata[ID_W-1:0]) < 32'(NUM_SRC))));
  a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wdata[ID_W-1:0]) >= 32'(NUM_SRC)) |=> ($stable(en) && $stable(mask)));
  a_r11_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en) && $stable(mask)));
  a_r6_ctrl_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !win_sel && addr == OFS_CTRL) |=> rdata[11:2] == ID_W'(NUM_SRC));
endmodule

// File: tb/irq_idx_ctrl_test.sv
`timescale 1ns/1ps
module irq_idx_ctrl_test;
  localparam int N = 64;
  localparam logic [31:0] NONE = 32'd1023;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic win_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic cpu_irq;

  logic [N-1:0] m_en, m_mask;
  int vec = 0, bad = 0;
  logic [31:0] q;

  irq_idx_ctrl #(.NUM_SRC(N), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .win_sel(win_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cpu_irq(cpu_irq));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_ack();
    for (int i = 0; i < N; i++)
      if (src_in[i] && m_en[i] && !m_mask[i]) return 32'(i);
    return NONE;
  endfunction

  function automatic logic exp_irq();
    return |(src_in & m_en & ~m_mask);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [7:0] a, input logic [31:0] d);
    int i;
    win_sel = w; addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    i = int'(d[9:0]);
    if (i < N) begin
      if (!w && a == 8'h30) m_en[i] = 1'b1;
      if (!w && a == 8'h34) m_en[i] = 1'b0;
      if (w && a == 8'h48)  m_mask[i] = 1'b1;
      if (w && a == 8'h4C)  m_mask[i] = 1'b0;
    end
  endtask

  task automatic rd(input logic w, input logic [7:0] a, output logic [31:0] d);
    win_sel = w; addr = a; rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic ack_chk(input string req);
    rd(1'b1, 8'h44, q);
    chk(req, q, exp_ack());
    chk(req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    m_en = '0; m_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    src_in = '1;
    @(negedge clk);
    chk("R1 irq", 32'(cpu_irq), 0);
    ack_chk("R1 ack");
    rd(1'b0, 8'h00, q);
    chk("R6 ctrl", q, 32'(N) << 2);
    @(negedge clk);
    chk("R7 idle rdata", rdata, 0);

    src_in = '0; src_in[5] = 1; src_in[9] = 1;
    wr(0, 8'h30, 5); wr(0, 8'h30, 9);
    ack_chk("R2 enabled but masked");
    wr(1, 8'h4C, 5); wr(1, 8'h4C, 9);
    ack_chk("R5 R7 lowest wins");
    chk("R7 value", q, 5);
    ack_chk("R11 repeat ack");
    chk("R11 same value", q, 5);
    wr(1, 8'h48, 5);
    ack_chk("R4 masked skip");
    chk("R4 value", q, 9);
    wr(0, 8'h34, 9);
    ack_chk("R3 disabled");
    chk("R3 none", q, NONE);
    chk("R8 irq low", 32'(cpu_irq), 0);

    src_in = '0; src_in[3] = 1; src_in[0] = 1;
    wr(1, 8'h4C, 3); wr(1, 8'h4C, 0);
    wr(0, 8'h30, N + 3);
    wr(0, 8'h30, 1023);
    ack_chk("R9 out of range ignored");
    chk("R9 none", q, NONE);
    wr(1, 8'h30, 3);
    wr(0, 8'h3C, 3);
    ack_chk("R10 wrong window ignored");
    chk("R10 none", q, NONE);
    rd(1, 8'h00, q);
    chk("R10 unused read", q, 0);
    rd(0, 8'h44, q);
    chk("R10 ack in global window", q, 0);
    wr(0, 8'h30, {22'h2AB, 10'd3});
    ack_chk("R2 upper bits ignored");
    chk("R2 value", q, 3);
    wr(0, 8'h30, 0);
    ack_chk("R7 source zero");
    chk("R7 zero", q, 0);
    src_in[N-1] = 1; src_in[0] = 0; src_in[3] = 0;
    wr(1, 8'h4C, N - 1); wr(0, 8'h30, N - 1);
    ack_chk("R7 top source");
    chk("R8 irq high", 32'(cpu_irq), 1);

    for (int k = 0; k < 500; k++) begin
      int op;
      logic [31:0] id;
      op = int'($urandom % 7);
      id = $urandom % (N + 4);
      case (op)
        0: wr(0, 8'h30, id);
        1: wr(0, 8'h34, id);
        2: wr(1, 8'h48, id);
        3: wr(1, 8'h4C, id);
        4: src_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        5: wr(1'($urandom), 8'h30 + 8'(4 * ($urandom % 8)), id);
        default: begin
          src_in = {$urandom, $urandom};
          @(negedge clk);
          chk("R8 comb irq", 32'(cpu_irq), 32'(exp_irq()));
        end
      endcase
      ack_chk("R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule